// File: doc/BRIEF.md
# Multi-Condition Interrupt Source Aggregator

This block collects a fixed set of level-sensitive interrupt sources and presents them to a processor as one level request. Each source has an enable counter and a configured number of governing enables, for example a mask bit, a priority field and a group switch. Enable and disable strobes move the counter one step at a time. The source counts as enabled only when the counter reaches its configured number. A source is pending when its latched level is high and it is enabled.

A running count of pending sources is kept, and the processor request stays high while that count is nonzero. When the processor acknowledges, it issues a lookup with its current 4-bit interrupt mask. One cycle later the block answers with the vector code of the lowest-numbered pending source. The answer is "nothing" when the mask is all ones, and an error flag when no source is pending.

A contiguous chain of sources is not driven from the per-source level pins. It is driven from a 4-bit encoded external priority level instead. Level 0 means nothing is requested, 1 is the lowest level and 15 the highest. The chain entry for a level is the level XOR 15, counted from the chain's first source. When the encoded level changes, the chosen entry is asserted and force-enabled, and every other chain entry is deasserted. Reset is asynchronous and active low, and its release passes through a two-stage synchroniser.

Top module: `intc_aggregator`

## Requirements
- R1: Source i has G(i) governing enables, where G(i)=1 inside the chain and G(i)=1+(i mod MAX_GOV) elsewhere. Its counter rises by one on `en_up[i]` and falls by one on `en_dn[i]`. A rise at G(i) and a fall at 0 are ignored, and a cycle with both strobes leaves the counter unchanged. The source is enabled only while the counter equals G(i).
- R2: A source outside the chain latches `src_lvl[i]` on each clock edge. It is pending on that edge when the latched level is 1 and it is enabled. `src_lvl` bits of chain sources have no effect.
- R3: `pend_count` equals the number of pending sources and follows their changes on the same clock edge.
- R4: `irq_out` is 1 exactly when the pending count is nonzero.
- R5: A lookup (`lk_req`=1) with `lk_imask`=4'hF gives, on the next edge, `lk_done`=1, `lk_hit`=0 and `lk_err`=0.
- R6: A lookup with a mask below 4'hF while some source is pending gives, on the next edge, `lk_done`=1, `lk_hit`=1 and `lk_vec`=VEC_BASE+VEC_STEP*i, where i is the lowest-numbered source pending at the request edge.
- R7: A lookup with a mask below 4'hF while no source is pending gives `lk_done`=1, `lk_hit`=0 and `lk_err`=1. `lk_hit` and `lk_err` are never both 1.
- R8: On an edge where `ext_lvl` differs from its value on the previous edge, chain entry (ext_lvl XOR 15), which is source CHAIN_BASE+(ext_lvl XOR 15), is asserted. If its counter is 0 the counter is set to 1. All other chain entries are deasserted, so level 0 deasserts the whole chain.
- R9: While reset is asserted, and after its release, all latched levels, enable counters, the pending count and `irq_out` are 0, and the recorded previous `ext_lvl` is 0.
- R10: While `ext_lvl` is held steady, the chain is not re-driven, so a disable strobe on the selected entry takes effect and stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Level input per source |
| en_up | input | NUM_SRC | Per-source enable strobe |
| en_dn | input | NUM_SRC | Per-source disable strobe |
| ext_lvl | input | 4 | Encoded external priority level |
| lk_req | input | 1 | Vector lookup request |
| lk_imask | input | 4 | Processor interrupt mask for the lookup |
| irq_out | output | 1 | Level request to the processor |
| pend_count | output | CNT_W | Number of pending sources |
| lk_done | output | 1 | Lookup answer valid (one cycle) |
| lk_hit | output | 1 | Answer carries a vector |
| lk_err | output | 1 | Lookup with no pending source |
| lk_vec | output | VEC_W | Vector code of the chosen source |

## Verification
On every cycle, the assertions check the following: each enable counter stays within its configured limit and moves by at most one step; the pending count matches the population of pending flags; the request line agrees with the count; at most one chain entry is selected; a hit and an error are never reported together; and an all-ones mask always yields an empty answer. Other behaviours only show up through the bench's scenarios, which compare against an independent model in the bench. These are: which source wins a lookup, the vector it returns, the ignored strobes at the counter limits, the force-enable and deassertion of chain entries when the encoded level changes, and a disable on the selected chain entry staying in force while the level is held.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_HIT    = 2'd1,
    LK_MASKED = 2'd2,
    LK_EMPTY  = 2'd3
  } lk_kind_e;

  // Number of enables that govern source idx.
  function automatic int gov_of(input int idx, input int chain_base,
                                input int chain_len, input int max_gov);
    if (idx >= chain_base && idx < chain_base + chain_len) return 1;
    return 1 + (idx % max_gov);
  endfunction

  function automatic bit in_chain(input int idx, input int chain_base,
                                  input int chain_len);
    return (idx >= chain_base) && (idx < chain_base + chain_len);
  endfunction

endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell #(
  parameter int EN_W     = 2,
  parameter int GOV      = 1,
  parameter bit IS_CHAIN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic chain_set,
  input  logic chain_clr,
  input  logic en_up,
  input  logic en_dn,
  output logic pend_q,
  output logic pend_d
);

  localparam logic [EN_W-1:0] GOV_V = EN_W'(GOV);

  logic            asrt_q, asrt_d;
  logic [EN_W-1:0] cnt_q, cnt_d;
  logic            cnt_en, asrt_en;

  // next-state
  always_comb begin
    if (chain_set)                 asrt_d = 1'b1;
    else if (chain_clr)            asrt_d = 1'b0;
    else if (IS_CHAIN)             asrt_d = asrt_q;
    else                           asrt_d = lvl_in;
    asrt_en = (asrt_d != asrt_q);

    cnt_d = cnt_q;
    if (chain_set && cnt_q == '0)
      cnt_d = EN_W'(1);
    else if (en_up && !en_dn && cnt_q != GOV_V)
      cnt_d = cnt_q + EN_W'(1);
    else if (en_dn && !en_up && cnt_q != '0)
      cnt_d = cnt_q - EN_W'(1);
    cnt_en = (cnt_d != cnt_q);

    pend_d = asrt_d && (cnt_d == GOV_V);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asrt_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (asrt_en) asrt_q <= asrt_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // R1: counter never passes its configured limit
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= GOV_V);

  // R1: counter moves by at most one step per cycle
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |->
      ((cnt_q == $past(cnt_q) + EN_W'(1)) || (cnt_q == $past(cnt_q) - EN_W'(1))));

  // R2: a pending source is latched high
  p_pend_needs_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> asrt_q);

endmodule

// File: rtl/intc_lvl_decode.sv
module intc_lvl_decode #(
  parameter int CHAIN_LEN = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           ext_lvl,
  output logic [CHAIN_LEN-1:0] chain_set,
  output logic [CHAIN_LEN-1:0] chain_clr
);

  logic [3:0] ext_q;
  logic       chg;
  logic [3:0] sel;

  always_comb begin
    chg = (ext_lvl != ext_q);
    sel = ext_lvl ^ 4'hF;
  end

  for (genvar j = 0; j < CHAIN_LEN; j++) begin : g_dec
    assign chain_set[j] = chg && (sel == 4'(j));
    assign chain_clr[j] = chg && (sel != 4'(j));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ext_q <= 4'h0;
    else if (chg) ext_q <= ext_lvl;
  end

  // R8: at most one chain entry is selected at a time
  p_one_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain_set));

  // R10: steady level re-drives nothing
  p_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_lvl == ext_q) |-> (chain_set == '0 && chain_clr == '0));

endmodule

// File: rtl/intc_pend_track.sv
module intc_pend_track #(
  parameter int NUM_SRC = 24,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_q,
  input  logic [NUM_SRC-1:0] pend_d,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               irq_q
);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] rises, falls;
  logic             irq_d;

  always_comb begin
    rises = CNT_W'($countones(pend_d & ~pend_q));
    falls = CNT_W'($countones(pend_q & ~pend_d));
    cnt_d = cnt_q + rises - falls;
    irq_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_d != cnt_q) cnt_q <= cnt_d;
      if (irq_d != irq_q) irq_q <= irq_d;
    end
  end

  // R3: running count matches the pending population
  p_cnt_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'($countones(pend_q)));

  // R4: request line agrees with the count
  p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (cnt_q != '0));

endmodule

// File: rtl/intc_vec_lookup.sv
module intc_vec_lookup
  import intc_agg_pkg::*;
#(
  parameter int NUM_SRC  = 24,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 'h200,
  parameter int VEC_STEP = 'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_q,
  input  logic               lk_req,
  input  logic [3:0]         lk_imask,
  output logic               lk_done,
  output logic               lk_hit,
  output logic               lk_err,
  output logic [VEC_W-1:0]   lk_vec
);

  lk_kind_e         kind_d;
  logic [VEC_W-1:0] vec_d;
  logic             found;

  always_comb begin
    found = 1'b0;
    vec_d = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        found = 1'b1;
        vec_d = VEC_W'(VEC_BASE + VEC_STEP * i);
      end
    end
    if (!lk_req)                kind_d = LK_IDLE;
    else if (lk_imask == 4'hF)  kind_d = LK_MASKED;
    else if (found)             kind_d = LK_HIT;
    else                        kind_d = LK_EMPTY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_err  <= 1'b0;
      lk_vec  <= '0;
    end else begin
      lk_done <= (kind_d != LK_IDLE);
      lk_hit  <= (kind_d == LK_HIT);
      lk_err  <= (kind_d == LK_EMPTY);
      lk_vec  <= (kind_d == LK_HIT) ? vec_d : '0;
    end
  end

  // R5: an all-ones mask yields an empty answer
  p_mask_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_imask == 4'hF) |=> (lk_done && !lk_hit && !lk_err));

  // R7: hit and error are exclusive
  p_hit_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_err));

  // R6: answers only follow a request
  p_done_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_done);

endmodule

// File: rtl/intc_aggregator.sv
module intc_aggregator
  import intc_agg_pkg::*;
#(
  parameter int NUM_SRC    = 24,
  parameter int VEC_W      = 12,
  parameter int VEC_BASE   = 'h200,
  parameter int VEC_STEP   = 'h20,
  parameter int MAX_GOV    = 3,
  parameter int CHAIN_BASE = 8,
  parameter int CHAIN_LEN  = 15,
  parameter int CNT_W      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] en_up,
  input  logic [NUM_SRC-1:0] en_dn,
  input  logic [3:0]         ext_lvl,
  input  logic               lk_req,
  input  logic [3:0]         lk_imask,
  output logic               irq_out,
  output logic [CNT_W-1:0]   pend_count,
  output logic               lk_done,
  output logic               lk_hit,
  output logic               lk_err,
  output logic [VEC_W-1:0]   lk_vec
);

  localparam int EN_W = $clog2(MAX_GOV + 1);

  // reset: asynchronous assertion, synchronised release
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [CHAIN_LEN-1:0] chain_set, chain_clr;
  logic [NUM_SRC-1:0]   pend_q, pend_d;

  intc_lvl_decode #(.CHAIN_LEN(CHAIN_LEN)) u_dec (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ext_lvl   (ext_lvl),
    .chain_set (chain_set),
    .chain_clr (chain_clr)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam bit IS_CH = in_chain(i, CHAIN_BASE, CHAIN_LEN);
    localparam int GOV_I = gov_of(i, CHAIN_BASE, CHAIN_LEN, MAX_GOV);
    logic c_set, c_clr;
    if (IS_CH) begin : g_ch
      assign c_set = chain_set[i - CHAIN_BASE];
      assign c_clr = chain_clr[i - CHAIN_BASE];
    end else begin : g_pl
      assign c_set = 1'b0;
      assign c_clr = 1'b0;
    end
    intc_src_cell #(.EN_W(EN_W), .GOV(GOV_I), .IS_CHAIN(IS_CH)) u_cell (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .lvl_in    (src_lvl[i]),
      .chain_set (c_set),
      .chain_clr (c_clr),
      .en_up     (en_up[i]),
      .en_dn     (en_dn[i]),
      .pend_q    (pend_q[i]),
      .pend_d    (pend_d[i])
    );
  end

  intc_pend_track #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_trk (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .pend_q (pend_q),
    .pend_d (pend_d),
    .cnt_q  (pend_count),
    .irq_q  (irq_out)
  );

  intc_vec_lookup #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_lk (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .pend_q   (pend_q),
    .lk_req   (lk_req),
    .lk_imask (lk_imask),
    .lk_done  (lk_done),
    .lk_hit   (lk_hit),
    .lk_err   (lk_err),
    .lk_vec   (lk_vec)
  );

  // R9: nothing is pending while the internal reset holds
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_i_n |-> (pend_count == '0 && !irq_out));

endmodule

// File: tb/tb_intc_aggregator.sv
module tb_intc_aggregator;
  localparam int N     = 24;
  localparam int CB    = 8;
  localparam int CL    = 15;
  localparam int MG    = 3;
  localparam int CNT_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src_lvl, en_up, en_dn;
  logic [3:0] ext_lvl, lk_imask;
  logic lk_req;
  logic irq_out, lk_done, lk_hit, lk_err;
  logic [CNT_W-1:0] pend_count;
  logic [11:0] lk_vec;

  always #10 clk = ~clk;

  intc_aggregator dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .en_up(en_up), .en_dn(en_dn),
    .ext_lvl(ext_lvl), .lk_req(lk_req), .lk_imask(lk_imask), .irq_out(irq_out),
    .pend_count(pend_count), .lk_done(lk_done), .lk_hit(lk_hit), .lk_err(lk_err),
    .lk_vec(lk_vec)
  );

  int tests = 0, fails = 0;
  bit m_asrt [N];
  int m_cnt  [N];
  int m_ext;
  int exp_kind; // 0 idle, 1 hit, 2 masked, 3 empty
  int exp_vec;
  bit done = 0;

  function automatic int gov(input int i);
    if (i >= CB && i < CB + CL) return 1;
    return 1 + (i % MG);
  endfunction

  function automatic bit is_ch(input int i);
    return i >= CB && i < CB + CL;
  endfunction

  function automatic bit m_pend(input int i);
    return m_asrt[i] && (m_cnt[i] == gov(i));
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m_pend(i));
    return c;
  endfunction

  function automatic int m_first();
    for (int i = 0; i < N; i++) if (m_pend(i)) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin m_asrt[i] = 0; m_cnt[i] = 0; end
    m_ext = 0;
  endtask

  // Drive one cycle at a negedge, update the model, check after the edge.
  task automatic step(input logic [N-1:0] lvl, input logic [N-1:0] up,
                      input logic [N-1:0] dn, input logic [3:0] ext,
                      input logic req, input logic [3:0] mask);
    bit chg;
    int sel;
    if (!req) exp_kind = 0;
    else if (mask == 4'hF) exp_kind = 2;
    else if (m_first() >= 0) begin
      exp_kind = 1;
      exp_vec = 'h200 + 'h20 * m_first();
    end else exp_kind = 3;
    src_lvl = lvl; en_up = up; en_dn = dn; ext_lvl = ext;
    lk_req = req; lk_imask = mask;
    chg = (int'(ext) != m_ext);
    sel = int'(ext) ^ 15;
    for (int i = 0; i < N; i++) begin
      bit fset = chg && is_ch(i) && (i - CB == sel);
      if (is_ch(i)) begin
        if (chg) m_asrt[i] = fset;
      end else m_asrt[i] = lvl[i];
      if (fset && m_cnt[i] == 0) m_cnt[i] = 1;
      else if (up[i] && !dn[i] && m_cnt[i] < gov(i)) m_cnt[i]++;
      else if (dn[i] && !up[i] && m_cnt[i] > 0) m_cnt[i]--;
    end
    if (chg) m_ext = int'(ext);
    @(posedge clk);
    @(negedge clk);
    chk("R3 pend_count", int'(pend_count), m_count());
    chk("R4 irq_out", int'(irq_out), int'(m_count() != 0));
    if (exp_kind != 0) begin
      chk("R5/R6/R7 lk_done", int'(lk_done), 1);
      if (exp_kind == 2) begin
        chk("R5 masked hit", int'(lk_hit), 0);
        chk("R5 masked err", int'(lk_err), 0);
      end else if (exp_kind == 1) begin
        chk("R6 hit", int'(lk_hit), 1);
        chk("R6 vector", int'(lk_vec), exp_vec);
      end else begin
        chk("R7 empty hit", int'(lk_hit), 0);
        chk("R7 empty err", int'(lk_err), 1);
      end
    end else chk("R6 no answer without request", int'(lk_done), 0);
  endtask

  task automatic idle(input logic [N-1:0] lvl, input logic [3:0] ext);
    step(lvl, '0, '0, ext, 1'b0, 4'h0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] lvl, up, dn;
    logic [3:0] ext;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; src_lvl = '0; en_up = '0; en_dn = '0; ext_lvl = 4'h0;
    lk_req = 1'b0; lk_imask = 4'h0;
    m_reset();
    repeat (3) @(negedge clk);
    // R9: quiet during reset
    chk("R9 reset pend_count", int'(pend_count), 0);
    chk("R9 reset irq", int'(irq_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after release irq", int'(irq_out), 0);
    // R7: lookup with nothing pending
    step('0, '0, '0, 4'h0, 1'b1, 4'h3);

    // R1: source 2 needs three enables
    lvl = '0; lvl[2] = 1'b1;
    idle(lvl, 4'h0);
    chk("R1 not yet enabled", int'(pend_count), 0);
    up = '0; up[2] = 1'b1;
    step(lvl, up, '0, 4'h0, 1'b0, 4'h0);
    step(lvl, up, '0, 4'h0, 1'b0, 4'h0);
    chk("R1 two of three", int'(pend_count), 0);
    step(lvl, up, '0, 4'h0, 1'b0, 4'h0);
    chk("R1 three of three", int'(pend_count), 1);
    step(lvl, up, '0, 4'h0, 1'b0, 4'h0);   // ignored at limit
    step(lvl, up, up, 4'h0, 1'b0, 4'h0);   // both strobes: no change
    chk("R1 both strobes", int'(pend_count), 1);
    step(lvl, '0, up, 4'h0, 1'b0, 4'h0);
    chk("R1 one disable", int'(pend_count), 0);
    step(lvl, up, '0, 4'h0, 1'b1, 4'h0);
    chk("R6 src2 pending", int'(pend_count), 1);
    step(lvl, '0, '0, 4'h0, 1'b1, 4'h0);   // expects vector of source 2
    step(lvl, '0, '0, 4'h0, 1'b1, 4'hF);   // R5 masked
    // R2: chain level pins ignored
    lvl[CB + 3] = 1'b1;
    idle(lvl, 4'h0);
    chk("R2 chain pin ignored", int'(pend_count), 1);
    lvl[2] = 1'b0;
    idle(lvl, 4'h0);
    chk("R2 level drop", int'(pend_count), 0);

    // R8: level 15 selects chain entry 0, forced enable
    idle(lvl, 4'hF);
    chk("R8 level 15 pending", int'(pend_count), 1);
    step(lvl, '0, '0, 4'hF, 1'b1, 4'h0);  // vector of source CB
    idle(lvl, 4'h1);                       // entry 14
    chk("R8 level 1 swap", int'(pend_count), 1);
    step(lvl, '0, '0, 4'h1, 1'b1, 4'h0);
    // R10: disable selected entry while level steady
    dn = '0; dn[CB + 14] = 1'b1;
    step(lvl, '0, dn, 4'h1, 1'b0, 4'h0);
    idle(lvl, 4'h1);
    idle(lvl, 4'h1);
    chk("R10 disable sticks", int'(pend_count), 0);
    idle(lvl, 4'h0);
    chk("R8 level 0 clears", int'(pend_count), 0);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < N; i++) if ($urandom % 8 == 0) lvl[i] = ~lvl[i];
      up = '0; dn = '0;
      for (int i = 0; i < N; i++) begin
        up[i] = ($urandom % 5 == 0);
        dn[i] = ($urandom % 7 == 0);
      end
      ext = ($urandom % 6 == 0) ? 4'($urandom) : ext_lvl;
      step(lvl, up, dn, ext, 1'($urandom % 3 == 0),
           ($urandom % 5 == 0) ? 4'hF : 4'($urandom % 15));
    end

    // R9: reset mid-run clears everything
    rst_n = 1'b0;
    m_reset();
    repeat (2) @(negedge clk);
    chk("R9 mid reset count", int'(pend_count), 0);
    chk("R9 mid reset irq", int'(irq_out), 0);
    src_lvl = '0; ext_lvl = 4'h0; lk_req = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step('0, '0, '0, 4'h0, 1'b1, 4'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule